// File: doc/BRIEF.md
# SPI Command Response Checker

This block sits on the host side of a byte-oriented SPI link to a peripheral. After the host sends a command frame, it tells the checker which opcode went out and whether the peripheral appends CRC bytes to its data. The checker then watches the bytes that come back one at a time and decides whether the transaction succeeded. For register reads it also collects the 32-bit result.

Each received byte goes through a fixed sequence of stages. Control commands first drop one leading byte. Then the opcode echo is searched for, then a zero status byte. Read commands then search for a data header. Single-word reads capture four data bytes, least significant first, and then consume any CRC bytes without comparing them. Each search stage has a bounded budget of non-matching bytes. When a budget runs out, the transaction ends in failure.

The state machine has these states. IDLE waits for `start`. SKIP drops the leading byte of a control command. ECHO searches for the opcode. STAT searches for the zero status byte. HDR searches for the data header. DATA captures the word. CRC consumes the trailing check bytes. PASS and FAIL each last one cycle and report the result.

The transitions are:
- IDLE to SKIP or ECHO on `start`.
- SKIP to ECHO on any byte.
- ECHO to STAT on an echo hit.
- STAT to PASS (non-read) or HDR (read) on a zero byte.
- HDR to PASS (block read) or DATA (word read) on a header hit.
- DATA to CRC or PASS after the fourth byte.
- CRC to PASS after the last check byte.
- ECHO, STAT or HDR to FAIL on the miss that exhausts the budget.
- PASS or FAIL back to IDLE unconditionally.

Top module: `spi_rsp_check`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done`, `ok` and `fail` are low and `rdata` is zero.
- R2: After `start`, each accepted byte is compared with the latched opcode. Up to 10 non-matching bytes are discarded. The 11th consecutive non-matching byte ends the transaction with `fail`.
- R3: For the control opcodes 0xCF, 0xC5 and 0xC6, the first accepted byte after `start` is discarded without comparison, even if it equals the opcode.
- R4: After the echo, accepted bytes are searched for the value 0x00 with the same budget: 10 discarded bytes allowed, and failure on the 11th consecutive nonzero byte.
- R5: For any opcode other than the four read opcodes, the transaction succeeds on the byte that satisfies the status search.
- R6: For the read opcodes 0xC4, 0xCA, 0xC2 and 0xC8, after the status byte the checker searches for a header byte whose bits 7:4 are 0xF, with the same 10-byte budget. The 11th consecutive miss fails.
- R7: For the block read opcodes 0xC2 and 0xC8, the transaction succeeds on the header byte.
- R8: For the word read opcodes 0xC4 and 0xCA, the four bytes after the header form `rdata` little-endian: the first byte goes to bits 7:0 and the fourth to bits 31:24. `rdata` changes only when a byte is accepted.
- R9: With `crc_en` high, a word read consumes two more bytes after the data, with any values, before succeeding. With `crc_en` low, it succeeds on the fourth data byte.
- R10: `done` is high for exactly one cycle, in the cycle after the final byte is accepted. In that cycle exactly one of `ok` and `fail` is high, and neither is high at any other time.
- R11: `start` is ignored while a transaction is in progress. Bytes are accepted only when `rx_valid` is high, and bytes presented while idle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin checking the response to `opcode` |
| opcode | input | 8 | Opcode that was sent, latched on an accepted `start` |
| crc_en | input | 1 | Peripheral appends CRC bytes to read data, latched with `start` |
| rx_valid | input | 1 | `rx_byte` carries a received byte this cycle |
| rx_byte | input | 8 | Received byte |
| done | output | 1 | One-cycle end-of-transaction pulse |
| ok | output | 1 | Transaction succeeded, qualifies `done` |
| fail | output | 1 | A search budget ran out, qualifies `done` |
| rdata | output | 32 | Little-endian word from the last word read |

## Verification
The bench builds the checker with its default parameters: a budget of 10 misses, 4 data bytes and 2 check bytes. It sweeps every opcode class against both CRC settings. For each search stage, it uses miss counts of 0, 1, 9, 10 and 11, which places both sides of every exhaustion boundary within reach. Because the sequences are fed back to back, the bench checks the exact cycle of each `done` pulse. It also checks that `done` stays low on every byte before that cycle, which is where a skipped leading byte or a missing CRC stage would show. Separate cases exercise a stray `start` in mid-transaction, bytes while idle, and gaps in `rx_valid`.

// File: rtl/spi_rsp_pkg.sv
package spi_rsp_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_BLK_RD     = 8'hC2;
    localparam logic [BYTE_W-1:0] OP_REG_RD     = 8'hC4;
    localparam logic [BYTE_W-1:0] OP_CTL_STOP   = 8'hC5;
    localparam logic [BYTE_W-1:0] OP_CTL_AGAIN  = 8'hC6;
    localparam logic [BYTE_W-1:0] OP_BLK_RD_EXT = 8'hC8;
    localparam logic [BYTE_W-1:0] OP_WORD_RD    = 8'hCA;
    localparam logic [BYTE_W-1:0] OP_CTL_RESET  = 8'hCF;

    localparam logic [BYTE_W-1:0] STATUS_GOOD = 8'h00;
    localparam logic [3:0]        HDR_NIBBLE  = 4'hF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SKIP,
        ST_ECHO,
        ST_STAT,
        ST_HDR,
        ST_DATA,
        ST_CRC,
        ST_PASS,
        ST_FAIL
    } rsp_state_t;

    typedef enum logic [1:0] {
        CK_PLAIN,
        CK_CTRL,
        CK_BLOCK_RD,
        CK_WORD_RD
    } cmd_kind_t;

endpackage

// File: rtl/spi_rsp_opdecode.sv
module spi_rsp_opdecode
    import spi_rsp_pkg::*;
(
    input  logic [BYTE_W-1:0] op,
    output cmd_kind_t         kind
);

    always_comb begin
        unique case (op)
            OP_CTL_RESET, OP_CTL_STOP, OP_CTL_AGAIN: kind = CK_CTRL;
            OP_BLK_RD, OP_BLK_RD_EXT:                kind = CK_BLOCK_RD;
            OP_REG_RD, OP_WORD_RD:                   kind = CK_WORD_RD;
            default:                                 kind = CK_PLAIN;
        endcase
    end

endmodule

// File: rtl/spi_rsp_budget.sv
module spi_rsp_budget #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic miss,
    output logic exhausted
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (miss && (cnt_q != LIM)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign exhausted = (cnt_q == LIM);

endmodule

// File: rtl/spi_rsp_word_asm.sv
module spi_rsp_word_asm
    import spi_rsp_pkg::*;
#(
    parameter int NBYTES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     take,
    input  logic [BYTE_W-1:0]        din,
    output logic [NBYTES*BYTE_W-1:0] word,
    output logic                     last
);

    localparam int IW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(NBYTES - 1);

    logic [IW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx_q <= '0;
        end else if (take && (idx_q != LAST_IDX)) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign last = (idx_q == LAST_IDX);

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (take && (idx_q == IW'(g))) begin
                lane_q <= din;
            end
        end
        assign word[g*BYTE_W +: BYTE_W] = lane_q;
    end

endmodule

// File: rtl/spi_rsp_check.sv
module spi_rsp_check
    import spi_rsp_pkg::*;
#(
    parameter int RETRY_LIMIT = 10,
    parameter int WORD_BYTES  = 4,
    parameter int CRC_BYTES   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [BYTE_W-1:0]            opcode,
    input  logic                         crc_en,
    input  logic                         rx_valid,
    input  logic [BYTE_W-1:0]            rx_byte,
    output logic                         done,
    output logic                         ok,
    output logic                         fail,
    output logic [WORD_BYTES*BYTE_W-1:0] rdata
);

    localparam int KW = (CRC_BYTES > 1) ? $clog2(CRC_BYTES) : 1;
    localparam logic [KW-1:0] CRC_LAST = KW'(CRC_BYTES - 1);

    rsp_state_t        state_q, state_d;
    logic [BYTE_W-1:0] op_q;
    cmd_kind_t         kind_q, kind_d;
    logic              crc_q;
    logic [KW-1:0]     crc_idx_q;

    logic hit_echo, hit_stat, hit_hdr;
    logic searching, miss, exhausted, budget_clr;
    logic data_take, data_last;

    spi_rsp_opdecode u_dec (
        .op   (opcode),
        .kind (kind_d)
    );

    assign hit_echo = (rx_byte == op_q);
    assign hit_stat = (rx_byte == STATUS_GOOD);
    assign hit_hdr  = (rx_byte[BYTE_W-1 -: 4] == HDR_NIBBLE);

    always_comb begin
        searching = 1'b0;
        miss      = 1'b0;
        unique case (state_q)
            ST_ECHO: begin searching = 1'b1; miss = rx_valid && !hit_echo; end
            ST_STAT: begin searching = 1'b1; miss = rx_valid && !hit_stat; end
            ST_HDR:  begin searching = 1'b1; miss = rx_valid && !hit_hdr;  end
            default: begin searching = 1'b0; miss = 1'b0;                  end
        endcase
    end

    assign budget_clr = !searching || (state_d != state_q);

    spi_rsp_budget #(.LIMIT(RETRY_LIMIT)) u_budget (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (budget_clr),
        .miss      (miss),
        .exhausted (exhausted)
    );

    assign data_take = (state_q == ST_DATA) && rx_valid;

    spi_rsp_word_asm #(.NBYTES(WORD_BYTES)) u_word (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_DATA),
        .take  (data_take),
        .din   (rx_byte),
        .word  (rdata),
        .last  (data_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = (kind_d == CK_CTRL) ? ST_SKIP : ST_ECHO;
            end
            ST_SKIP: begin
                if (rx_valid) state_d = ST_ECHO;
            end
            ST_ECHO: begin
                if (rx_valid) begin
                    if (hit_echo)       state_d = ST_STAT;
                    else if (exhausted) state_d = ST_FAIL;
                end
            end
            ST_STAT: begin
                if (rx_valid) begin
                    if (hit_stat) begin
                        state_d = (kind_q == CK_BLOCK_RD || kind_q == CK_WORD_RD)
                                  ? ST_HDR : ST_PASS;
                    end else if (exhausted) begin
                        state_d = ST_FAIL;
                    end
                end
            end
            ST_HDR: begin
                if (rx_valid) begin
                    if (hit_hdr)        state_d = (kind_q == CK_WORD_RD) ? ST_DATA : ST_PASS;
                    else if (exhausted) state_d = ST_FAIL;
                end
            end
            ST_DATA: begin
                if (rx_valid && data_last) begin
                    state_d = (crc_q && CRC_BYTES > 0) ? ST_CRC : ST_PASS;
                end
            end
            ST_CRC: begin
                if (rx_valid && (crc_idx_q == CRC_LAST)) state_d = ST_PASS;
            end
            ST_PASS: state_d = ST_IDLE;
            ST_FAIL: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and per-transaction context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            op_q      <= '0;
            kind_q    <= CK_PLAIN;
            crc_q     <= 1'b0;
            crc_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                op_q   <= opcode;
                kind_q <= kind_d;
                crc_q  <= crc_en;
            end
            if (state_q != ST_CRC) begin
                crc_idx_q <= '0;
            end else if (rx_valid && crc_idx_q != CRC_LAST) begin
                crc_idx_q <= crc_idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        done = (state_q == ST_PASS) || (state_q == ST_FAIL);
        ok   = (state_q == ST_PASS);
        fail = (state_q == ST_FAIL);
    end

endmodule

// File: rtl/spi_rsp_check_sva.sv
module spi_rsp_check_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        rx_valid,
    input logic        done,
    input logic        ok,
    input logic        fail,
    input logic [31:0] rdata
);

    logic busy_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     busy_q <= 1'b0;
        else if (done)  busy_q <= 1'b0;
        else if (start) busy_q <= 1'b1;
    end

    assert_done_one_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ok != fail));

    assert_result_needs_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ok || fail) |-> done);

    assert_done_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_follows_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rx_valid));

    assert_done_only_when_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy_q);

    assert_rdata_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(rdata));

endmodule

bind spi_rsp_check spi_rsp_check_sva u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .rx_valid (rx_valid),
    .done     (done),
    .ok       (ok),
    .fail     (fail),
    .rdata    (rdata)
);

// File: tb/spi_rsp_check_tb.sv
module spi_rsp_check_tb;

    localparam int LIMIT = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic        crc_en = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        done, ok, fail;
    logic [31:0] rdata;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    spi_rsp_check #(.RETRY_LIMIT(LIMIT), .WORD_BYTES(4), .CRC_BYTES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .crc_en(crc_en),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .done(done), .ok(ok), .fail(fail),
        .rdata(rdata)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog: actual %0d cycles, expected fewer than 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit cond, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
        end
    endtask

    function automatic bit is_ctrl(input logic [7:0] op);
        return op == 8'hCF || op == 8'hC5 || op == 8'hC6;
    endfunction
    function automatic bit is_word(input logic [7:0] op);
        return op == 8'hC4 || op == 8'hCA;
    endfunction
    function automatic bit is_read(input logic [7:0] op);
        return is_word(op) || op == 8'hC2 || op == 8'hC8;
    endfunction

    // gap: insert an idle cycle after every accepted byte
    task automatic run_txn(input logic [7:0] op, input bit crc, input int me, input int ms,
                           input int mh, input logic [31:0] w, input string tag,
                           input bit mid_start, input bit gap);
        logic [7:0] q[$];
        bit exp_ok = 1'b1;
        bit stop = 1'b0;
        if (is_ctrl(op)) q.push_back(op);
        if (me > LIMIT) begin
            repeat (LIMIT + 1) q.push_back(op ^ 8'h10);
            exp_ok = 1'b0; stop = 1'b1;
        end else begin
            repeat (me) q.push_back(op ^ 8'h10);
            q.push_back(op);
        end
        if (!stop) begin
            if (ms > LIMIT) begin
                repeat (LIMIT + 1) q.push_back(8'h5A);
                exp_ok = 1'b0; stop = 1'b1;
            end else begin
                repeat (ms) q.push_back(8'h5A);
                q.push_back(8'h00);
            end
        end
        if (!stop && is_read(op)) begin
            if (mh > LIMIT) begin
                repeat (LIMIT + 1) q.push_back(8'h7E);
                exp_ok = 1'b0; stop = 1'b1;
            end else begin
                repeat (mh) q.push_back(8'h7E);
                q.push_back(8'hF3);
            end
        end
        if (!stop && is_word(op)) begin
            q.push_back(w[7:0]);
            q.push_back(w[15:8]);
            q.push_back(w[23:16]);
            q.push_back(w[31:24]);
            if (crc) begin
                q.push_back(8'h9C);
                q.push_back(8'h21);
            end
        end

        @(negedge clk);
        opcode = op; crc_en = crc; start = 1'b1;
        @(negedge clk);
        start = 1'b0; opcode = 8'h00; crc_en = ~crc;
        for (int i = 0; i < q.size(); i++) begin
            rx_valid = 1'b1;
            rx_byte  = q[i];
            if (mid_start && i == 0) begin
                start = 1'b1; opcode = 8'hC9;
            end
            @(negedge clk);
            rx_valid = 1'b0;
            start    = 1'b0;
            if (i < q.size() - 1) begin
                check(done == 1'b0, "R10", "done before final byte", 32'(done), 32'd0);
                if (gap) begin
                    rx_byte = op;
                    @(negedge clk);
                    check(done == 1'b0, "R11", "done during rx_valid gap", 32'(done), 32'd0);
                end
            end else begin
                check(done == 1'b1, tag, "done after final byte", 32'(done), 32'd1);
                check(ok == exp_ok && fail == !exp_ok, tag, "result {ok,fail}",
                      {30'd0, ok, fail}, {30'd0, exp_ok, !exp_ok});
            end
        end
        if (exp_ok && is_word(op)) begin
            check(rdata == w, "R8", "little-endian word", rdata, w);
        end
        @(negedge clk);
        check(done == 1'b0 && ok == 1'b0 && fail == 1'b0, "R10", "pulse length",
              {29'd0, done, ok, fail}, 32'd0);
    endtask

    initial begin
        logic [7:0] ops[11];
        int         mvals[5];
        string      stag[3];
        ops   = '{8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5, 8'hC6, 8'hC7, 8'hC8, 8'hC9, 8'hCA, 8'hCF};
        mvals = '{0, 1, LIMIT - 1, LIMIT, LIMIT + 1};
        stag  = '{"R2", "R4", "R6"};

        repeat (3) @(negedge clk);
        check(done == 1'b0 && ok == 1'b0 && fail == 1'b0, "R1", "flags in reset",
              {29'd0, done, ok, fail}, 32'd0);
        check(rdata == 32'd0, "R1", "rdata in reset", rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && rdata == 32'd0, "R1", "state after reset",
              {31'd0, done}, 32'd0);

        // R11: bytes while idle do nothing
        for (int k = 0; k < 4; k++) begin
            rx_valid = 1'b1; rx_byte = (k == 0) ? 8'hCA : 8'h00;
            @(negedge clk);
            rx_valid = 1'b0;
            check(done == 1'b0, "R11", "idle byte", 32'(done), 32'd0);
        end

        // directed cases
        run_txn(8'hC5, 1'b0, 0, 0, 0, 32'h0, "R3", 1'b0, 1'b0);
        run_txn(8'hCF, 1'b1, 2, 1, 0, 32'h0, "R3", 1'b0, 1'b0);
        run_txn(8'hC9, 1'b1, 1, 2, 0, 32'h0, "R5", 1'b0, 1'b0);
        run_txn(8'hC8, 1'b1, 0, 0, 3, 32'h0, "R7", 1'b0, 1'b0);
        run_txn(8'hCA, 1'b1, 0, 0, 0, 32'hDEADBEEF, "R9", 1'b0, 1'b0);
        run_txn(8'hCA, 1'b0, 0, 0, 0, 32'h01234567, "R9", 1'b0, 1'b0);
        run_txn(8'hC4, 1'b1, 3, 2, 1, 32'h89ABCDEF, "R8", 1'b0, 1'b1);
        run_txn(8'hCA, 1'b0, 0, 0, 0, 32'hA5A55A5A, "R11", 1'b1, 1'b0);

        // sweep over opcodes, CRC setting, stage and miss count
        foreach (ops[oi]) begin
            for (int c = 0; c < 2; c++) begin
                for (int s = 0; s < 3; s++) begin
                    if (s == 2 && !is_read(ops[oi])) continue;
                    foreach (mvals[mi]) begin
                        logic [31:0] w;
                        w = {ops[oi], 8'(mi * 37 + s), (c != 0) ? 8'hA7 : 8'h3B, ops[oi] ^ 8'h55};
                        run_txn(ops[oi], c[0],
                                (s == 0) ? mvals[mi] : 0,
                                (s == 1) ? mvals[mi] : 0,
                                (s == 2) ? mvals[mi] : 0,
                                w, stag[s], 1'b0, 1'b0);
                    end
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule